// File: doc/BRIEF.md
# Software-Driven SPI Flash Byte Engine

This block is an SPI master run entirely by software through one 32-bit access register. A write to the register loads up to three data bytes, a byte-count code and a chip-select level. If the write also sets the start bit, the engine shifts the chosen number of bytes out to the flash in SPI mode 0, most significant bit first. Each byte that goes out is replaced in its own slot by the byte that came back from the flash during that byte.

The chip-select pin follows a register bit that only software changes. A complete flash command, such as an opcode, an address and a stream of data, can therefore be built from several transfers under one continuous select. A ready flag tells software when the current transfer has finished and the received bytes can be read. The serial clock is the system clock divided by a parameter.

Top module: `spi_flash_access`

## Requirements
- R1: After reset the register reads 0x10000000 (ready set, select clear, all data zero), `spi_cs_n` is high and `spi_sck` is low.
- R2: The count field (bits 25:24) selects the transfer length: code 0 sends 1 byte, code 1 sends 2 bytes, and codes 2 and 3 both send 3 bytes. A transfer lasts exactly 16*HALF_DIV clock cycles per byte, and each SCK phase is HALF_DIV cycles long.
- R3: Bytes leave in slot order: slot 0 (bits 7:0), then slot 1 (bits 15:8), then slot 2 (bits 23:16). Each byte goes out most significant bit first on `spi_mosi`.
- R4: When a transfer completes, every slot that was sent holds the byte sampled on `spi_miso` during that byte, MSB first. Slots that were not sent keep the value written.
- R5: The start bit (bit 26) starts a transfer only when it is written as 1, and it always reads back as 0.
- R6: Select bit 27 drives `spi_cs_n` to its inverse and is held across transfers. A write without the start bit updates the select and the data but produces no SCK activity.
- R7: Ready bit 28 reads 0 from the cycle after a start is accepted until the transfer ends, and reads 1 otherwise.
- R8: SPI mode 0 applies: SCK idles low, MISO is sampled on the rising SCK edge, and MOSI changes only together with a falling SCK edge while a transfer runs.
- R9: A register write made while a transfer is running is ignored completely, including its start bit, its select bit and its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the access register |
| reg_wdata | input | 32 | Write data for the access register |
| reg_rdata | output | 32 | Current access register contents |
| spi_sck | output | 1 | SPI serial clock, idles low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |
| spi_cs_n | output | 1 | Active-low flash select |

## Verification
The assertions check on every cycle that SCK stays low whenever no transfer runs, that MOSI moves only with a falling SCK edge, that each SCK phase lasts exactly the divider count, that select and count stay frozen while busy, that a transfer starts only from a write carrying the start bit, and that the slot index never passes the last slot. Only the bench scenarios can show the data path end to end: the bytes observed on MOSI, the received bytes landing in the right slots while unsent slots keep their value, the exact transfer length for every count code, and that a write made mid-transfer leaves no trace in the final register value.

// File: rtl/spi_acc_pkg.sv
// Package: field layout of the access register and shared helpers.
// Assumes a 32-bit register with three byte slots in the low 24 bits.
package spi_acc_pkg;
    localparam int REG_W     = 32;
    localparam int NUM_SLOTS = 3;
    localparam int SLOT_W    = 8;
    localparam int DATA_W    = NUM_SLOTS * SLOT_W;
    localparam int CNT_LSB   = 24;
    localparam int START_BIT = 26;
    localparam int SEL_BIT   = 27;
    localparam int RDY_BIT   = 28;

    // Maps the count code to the index of the last slot sent (code 3 acts as code 2).
    function automatic logic [1:0] last_slot_of(input logic [1:0] code);
        logic [1:0] r;
        case (code)
            2'd0:    r = 2'd0;
            2'd1:    r = 2'd1;
            default: r = 2'd2;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/spi_sck_div.sv
// Serial clock divider: while run is high, toggles sck every HALF_DIV
// system clocks and flags the cycle of each rising and falling edge.
// Assumes run stays high for whole SCK periods; sck is forced low when idle.
module spi_sck_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          expire;

    assign expire = (cnt_q == LAST);
    assign rise_o = run && expire && !sck;
    assign fall_o = run && expire && sck;

    // Phase counter and SCK level register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            sck   <= 1'b0;
        end else if (expire) begin
            cnt_q <= '0;
            sck   <= ~sck;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Each SCK phase lasts exactly HALF_DIV system clocks.
    assert_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && (sck != $past(sck))) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/spi_byte_shifter.sv
// Byte shifter: holds the byte in flight, presents its MSB on mosi,
// captures miso on a rising SCK edge and shifts on a falling edge.
// Assumes load never coincides with rise; load wins over a shift.
module spi_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_byte,
    input  logic         rise,
    input  logic         fall,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] next_byte
);
    logic [W-1:0] sreg_q;
    logic         rx_q;

    assign mosi      = sreg_q[W-1];
    assign next_byte = {sreg_q[W-2:0], rx_q};

    // Shift register: load a new byte or shift in the sampled bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= load_byte;
        end else if (fall) begin
            sreg_q <= next_byte;
        end
    end

    // Sampled MISO bit, captured on the rising SCK edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= 1'b0;
        end else if (rise) begin
            rx_q <= miso;
        end
    end
endmodule

// File: rtl/spi_flash_access.sv
// Top: software access register plus byte sequencer for an SPI mode 0
// master. A write while idle loads data, count and select; a set start
// bit launches 1..3 bytes, each overwritten by the byte received with it.
// Assumes software polls the ready bit; writes while busy are dropped.
module spi_flash_access
    import spi_acc_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_cs_n
);
    localparam int BITW = $clog2(SLOT_W);

    logic [NUM_SLOTS-1:0][SLOT_W-1:0] data_q;
    logic [1:0]      cnt_q;
    logic            sel_q;
    logic            busy_q;
    logic [BITW-1:0] bit_q;
    logic [1:0]      slot_q;
    logic [1:0]      last_slot;
    logic            accept_wr;
    logic            start_req;
    logic            rise;
    logic            fall;
    logic            byte_done;
    logic            more_bytes;
    logic            sh_load;
    logic [SLOT_W-1:0] sh_load_byte;
    logic [SLOT_W-1:0] rx_byte;
    logic [1:0]      next_slot;

    assign last_slot  = last_slot_of(cnt_q);
    assign accept_wr  = reg_wr && !busy_q;
    assign start_req  = accept_wr && reg_wdata[START_BIT];
    assign byte_done  = busy_q && fall && (bit_q == BITW'(SLOT_W - 1));
    assign more_bytes = (slot_q != last_slot);
    assign next_slot  = slot_q + 2'd1;

    // Shifter is loaded at start and at each byte boundary with more to send.
    assign sh_load      = start_req || (byte_done && more_bytes);
    assign sh_load_byte = start_req ? reg_wdata[SLOT_W-1:0] : data_q[next_slot];

    spi_sck_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy_q),
        .sck    (spi_sck),
        .rise_o (rise),
        .fall_o (fall)
    );

    spi_byte_shifter #(.W(SLOT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_byte (sh_load_byte),
        .rise      (rise),
        .fall      (fall),
        .miso      (spi_miso),
        .mosi      (spi_mosi),
        .next_byte (rx_byte)
    );

    // Per-slot data registers: software write when idle, received byte on completion.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[g] <= '0;
            end else if (accept_wr) begin
                data_q[g] <= reg_wdata[g*SLOT_W +: SLOT_W];
            end else if (byte_done && (slot_q == 2'(g))) begin
                data_q[g] <= rx_byte;
            end
        end
    end

    // Configuration fields: count and select, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= 2'd0;
            sel_q <= 1'b0;
        end else if (accept_wr) begin
            cnt_q <= reg_wdata[CNT_LSB +: 2];
            sel_q <= reg_wdata[SEL_BIT];
        end
    end

    // Sequencer: busy flag, bit counter within the byte, current slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            bit_q  <= '0;
            slot_q <= 2'd0;
        end else if (start_req) begin
            busy_q <= 1'b1;
            bit_q  <= '0;
            slot_q <= 2'd0;
        end else if (busy_q && fall) begin
            bit_q <= bit_q + 1'b1;
            if (byte_done) begin
                if (more_bytes) begin
                    slot_q <= next_slot;
                end else begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    // Register read view: the start bit always reads as zero.
    always_comb begin
        reg_rdata                   = '0;
        reg_rdata[DATA_W-1:0]       = data_q;
        reg_rdata[CNT_LSB +: 2]     = cnt_q;
        reg_rdata[SEL_BIT]          = sel_q;
        reg_rdata[RDY_BIT]          = !busy_q;
    end

    assign spi_cs_n = !sel_q;

    // SCK idles low outside a transfer.
    assert_sck_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !spi_sck);

    // MOSI moves only together with a falling SCK edge during a transfer.
    assert_mosi_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && !$fell(spi_sck)) |-> $stable(spi_mosi));

    // Select and count cannot change while a transfer runs.
    assert_busy_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_q) |-> ($stable(sel_q) && $stable(cnt_q)));

    // A transfer only begins from a write carrying the start bit.
    assert_start_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(reg_wr && reg_wdata[START_BIT]));

    // The slot index never passes the last slot of the selected count.
    assert_slot_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (slot_q <= last_slot));
endmodule

// File: tb/spi_flash_access_bench.sv
module spi_flash_access_bench;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck;
    logic        spi_mosi;
    logic        spi_miso;
    logic        spi_cs_n;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Flash model state
    logic [23:0] slave_word = '0;
    logic [23:0] mosi_word = '0;
    int nrise = 0;
    int nfall = 0;

    always #5 clk = ~clk;

    spi_flash_access #(.HALF_DIV(HALF)) u_spi_flash_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_cs_n  (spi_cs_n)
    );

    function automatic int bit_pos(input int n);
        return 8 * (n / 8) + 7 - (n % 8);
    endfunction

    assign spi_miso = (nfall < 24) ? slave_word[bit_pos(nfall)] : 1'b0;

    always @(posedge spi_sck) begin
        if (nrise < 24) mosi_word[bit_pos(nrise)] = spi_mosi;
        nrise = nrise + 1;
    end

    always @(negedge spi_sck) nfall = nfall + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic run_xfer(input int c, input int p);
        logic [23:0] tx;
        logic [23:0] exp_d;
        logic [23:0] got_mosi;
        logic [31:0] exp_r;
        int nb;
        int cyc;
        tx = 24'(p * 32'h3B5A7 + c * 32'h1111 + 32'h0F1E2D);
        slave_word = ~tx ^ 24'(p * 32'h2468AC);
        mosi_word = '0;
        nrise = 0;
        nfall = 0;
        nb = (c == 0) ? 1 : (c == 1) ? 2 : 3;
        exp_d = tx;
        for (int i = 0; i < 3; i++)
            if (i < nb) exp_d[8*i +: 8] = slave_word[8*i +: 8];
        // start: select=1, start=1, count=c
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = {3'b000, 1'b0, 1'b1, 1'b1, 2'(c), tx};
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
        cyc = 0;
        while (reg_rdata[28] !== 1'b1 && cyc < 1000) begin
            cyc++;
            if (cyc == 5) begin
                // mid-transfer view: ready 0, start reads 0, data untouched
                check(reg_rdata == {3'b000, 1'b0, 1'b1, 1'b0, 2'(c), tx},
                      "R7/R5 busy view", reg_rdata, {3'b000, 1'b0, 1'b1, 1'b0, 2'(c), tx});
                check(spi_cs_n == 1'b0, "R6 select low during transfer",
                      32'(spi_cs_n), 32'd0);
                // R9: write during busy with start, select off, other data
                reg_wr    = 1'b1;
                reg_wdata = {3'b000, 1'b0, 1'b0, 1'b1, 2'd3, ~tx};
            end
            if (cyc == 6) begin
                reg_wr    = 1'b0;
                reg_wdata = '0;
            end
            @(negedge clk);
        end
        reg_wr    = 1'b0;
        reg_wdata = '0;
        check(cyc == 16 * HALF * nb, "R2 transfer length", 32'(cyc), 32'(16 * HALF * nb));
        check(nrise == 8 * nb, "R2 SCK rising edge count", 32'(nrise), 32'(8 * nb));
        got_mosi = '0;
        for (int i = 0; i < 3; i++)
            if (i < nb) got_mosi[8*i +: 8] = mosi_word[8*i +: 8];
        exp_r = '0;
        for (int i = 0; i < 3; i++)
            if (i < nb) exp_r[8*i +: 8] = tx[8*i +: 8];
        check(got_mosi == exp_r[23:0], "R3 MOSI byte order and MSB first",
              32'(got_mosi), exp_r);
        exp_r = {3'b000, 1'b1, 1'b1, 1'b0, 2'(c), exp_d};
        check(reg_rdata == exp_r, "R4/R9 result slots", reg_rdata, exp_r);
        check(spi_cs_n == 1'b0 && spi_sck == 1'b0, "R6/R8 select held, SCK idle",
              {30'd0, spi_cs_n, spi_sck}, 32'd0);
    endtask

    initial begin
        int rise_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(reg_rdata == 32'h1000_0000, "R1 reset value", reg_rdata, 32'h1000_0000);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 pins after reset",
              {30'd0, spi_cs_n, spi_sck}, 32'd2);

        for (int c = 0; c < 4; c++)
            for (int p = 0; p < 4; p++)
                run_xfer(c, p);

        // R6: write without start deselects, loads data, no SCK activity
        rise_before = nrise;
        reg_write({3'b000, 1'b0, 1'b0, 1'b0, 2'd1, 24'hA5C3E1});
        repeat (40) @(negedge clk);
        check(spi_cs_n == 1'b1, "R6 deselect", 32'(spi_cs_n), 32'd1);
        check(nrise == rise_before, "R6 no SCK without start", 32'(nrise), 32'(rise_before));
        check(reg_rdata == 32'h11A5_C3E1, "R5/R6 plain write view", reg_rdata, 32'h11A5_C3E1);

        // R1: reset again restores the default value
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(reg_rdata == 32'h1000_0000, "R1 reset after use", reg_rdata, 32'h1000_0000);

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule